// File: doc/BRIEF.md
# Interrupt Controller Mode and Access Translator

This block is the register front end of a per-core local interrupt controller. It owns the control register that holds the controller's base page, its enable bit and its extended-mode bit. Every register access is sent through it before it reaches the controller's internal register file. An access arrives in one of two styles. In legacy style it carries a byte offset whose low nibble must be zero. In extended style it carries a flat register index that starts at a fixed base index. The block turns either style into one internal word index, and it stops any access that the current mode does not allow.

Mode changes pass through the same control register, and the block enforces which changes are legal. Moving from legacy into extended mode needs only the extended bit set while the controller stays enabled. Leaving extended mode takes two writes: the first clears enable and extended together, and the second enables again in legacy mode. Each access gets one response in the cycle after it is presented. A rejected control write or a rejected access raises a one-cycle error pulse and changes nothing.

Top module: `intc_access_xlate`

## Requirements
- R1: After reset the mode is legacy, the enable bit (bit 11) reads 1, the extended bit (bit 10) reads 0, the base page field reads its default 0xFEE00, and no response or error is pending.
- R2: A legacy-style access whose offset has any of bits [3:0] set is rejected, and a rejected write leaves the addressed register unchanged.
- R3: A legacy-style access to offset `o` reaches internal index `o >> 4`. Offsets with any bit at or above bit IDX_W+4 set are rejected.
- R4: An extended-style access to index `a` reaches internal index `a - EXT_BASE`. Indices below EXT_BASE or at EXT_BASE + 2^IDX_W and above are rejected.
- R5: In disabled mode every access is rejected. An extended-style access in legacy mode is rejected, and so is a legacy-style access in extended mode.
- R6: In extended mode the destination-format register (internal index DFR_IDX) cannot be reached.
- R7: The command register is internal index CMD_IDX, with its upper half at CMD_IDX+1. A 64-bit access (wide = 1) is legal only in extended mode and only at CMD_IDX, where it moves the low word to CMD_IDX and the high word to CMD_IDX+1. In extended mode a 32-bit access to CMD_IDX+1 is rejected, a 32-bit write to CMD_IDX is rejected, and a 32-bit read of CMD_IDX is accepted.
- R8: From legacy mode, a control write that keeps enable at 1 and sets extended to 1 is accepted and selects extended mode.
- R9: From extended mode, a write of enable=1, extended=0 is rejected, and so is enable=0, extended=1. A write of enable=0, extended=0 is accepted and disables the controller, and a later write of enable=1, extended=0 returns it to legacy mode.
- R10: In disabled mode, any control write with extended=1 is rejected.
- R11: A response comes in the cycle after each access, with valid high for that one cycle. A rejected access returns error 1 and data zero. An accepted read returns the register file word (both words when wide), and an accepted write returns zero data. Each error pulse, on control writes or on accesses, lasts one cycle.
- R12: An accepted control write stores bits [PHYS_W-1:12] as the base page. All other control bits except 11 and 10 read as zero. A rejected control write leaves the base page and both mode bits unchanged.
- R13: The mode output encodes disabled as 2'b00, legacy as 2'b01 and extended as 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 64 | Control write data: base page, enable (bit 11), extended (bit 10) |
| ctl_rdata | output | 64 | Current control register contents |
| ctl_err | output | 1 | One-cycle pulse after a rejected control write |
| mode | output | 2 | 00 disabled, 01 legacy, 10 extended |
| acc_req | input | 1 | Register access request, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_ext | input | 1 | 1 = extended-style index, 0 = legacy-style offset |
| acc_wide | input | 1 | 1 = 64-bit access |
| acc_addr | input | ADDR_W | Legacy offset or extended index |
| acc_wdata | input | 64 | Write data (low word used for 32-bit writes) |
| rsp_valid | output | 1 | Response strobe, one cycle after acc_req |
| rsp_err | output | 1 | Access was rejected |
| rsp_rdata | output | 64 | Read data, zero on rejection and on writes |
| rf_rd | output | 1 | Read strobe to the internal register file |
| rf_wr | output | 1 | Write strobe to the internal register file |
| rf_wide | output | 1 | Access covers rf_idx and rf_idx+1 |
| rf_idx | output | IDX_W | Internal word index |
| rf_wdata | output | 64 | Write data to the register file |
| rf_rdata | input | 64 | Combinational read data, {word idx+1, word idx} |

## Verification
The bench builds the block with a 40-bit physical address, a 12-bit access address, a 6-bit internal index (64 words), an extended base of 0x800, the destination-format word at 0x0E and the command word at 0x30. With these values both window edges can be reached in each style: 0x7FF and 0x840 in extended style, and offset 0x400 in legacy style. Both halves of the command register, with their separate read and write rules, are also reachable. Random control writes with random bits drive the mode machine through every legal and illegal transition, and random accesses are checked against a shadow of the stub register file, so a rejected write that still lands shows up on a later read.

// File: rtl/intc_xlate_pkg.sv
// Package: shared mode type, control-bit positions and the transition rule.
// Assumes control bits 11 (enable) and 10 (extended) are fixed by the register layout.
package intc_xlate_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_LEGACY = 2'b01,
        MODE_EXT    = 2'b10
    } intc_mode_e;

    localparam int CTL_EN_BIT  = 11;
    localparam int CTL_EXT_BIT = 10;

    // Legal moves: off->{off,legacy}, legacy->{legacy,ext,off}, ext->{ext,off}.
    function automatic logic mode_step_ok(input logic cur_en, input logic cur_ext,
                                          input logic nxt_en, input logic nxt_ext);
        logic ok;
        if (!cur_en)      ok = !nxt_ext;
        else if (!cur_ext) ok = nxt_en || !nxt_ext;
        else              ok = (nxt_en == nxt_ext);
        return ok;
    endfunction

endpackage

// File: rtl/intc_mode_ctrl.sv
// Module: control register holding base page, enable and extended bits.
// It applies a write only when the mode change is legal, and pulses err_o for
// one cycle when it is not. Assumes PHYS_W is between 13 and 63.
module intc_mode_ctrl
    import intc_xlate_pkg::*;
#(
    parameter int PHYS_W = 40,
    parameter logic [PHYS_W-13:0] BASE_RST = 'hFEE00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [63:0] wdata_i,
    output logic [63:0] rdata_o,
    output logic        err_o,
    output intc_mode_e  mode_o
);
    localparam int BASE_W = PHYS_W - 12;

    logic              en_q, ext_q, err_q;
    logic [BASE_W-1:0] base_q;
    logic              step_ok;
    logic              unused_bits;

    assign unused_bits = ^{wdata_i[63:PHYS_W], wdata_i[9:0]};

    // Legality of the requested mode change.
    assign step_ok = mode_step_ok(en_q, ext_q, wdata_i[CTL_EN_BIT], wdata_i[CTL_EXT_BIT]);

    // Register update: accepted writes load everything, rejected ones only flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b1;
            ext_q  <= 1'b0;
            base_q <= BASE_RST;
            err_q  <= 1'b0;
        end else begin
            err_q <= wr_i && !step_ok;
            if (wr_i && step_ok) begin
                en_q   <= wdata_i[CTL_EN_BIT];
                ext_q  <= wdata_i[CTL_EXT_BIT];
                base_q <= wdata_i[PHYS_W-1:12];
            end
        end
    end

    // Readback image of the control register.
    always_comb begin
        rdata_o              = '0;
        rdata_o[PHYS_W-1:12] = base_q;
        rdata_o[CTL_EN_BIT]  = en_q;
        rdata_o[CTL_EXT_BIT] = ext_q;
    end

    // Mode encoding from the two state bits.
    always_comb begin
        if (ext_q)     mode_o = MODE_EXT;
        else if (en_q) mode_o = MODE_LEGACY;
        else           mode_o = MODE_OFF;
    end

    assign err_o = err_q;

    AST_NO_EXT_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ext_q |-> en_q);  // R10
    AST_EXT_EXIT_VIA_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_q && !ext_q == 1'b0) |=> (ext_q || !en_q));  // R9
    AST_EXT_ENTRY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_q) |-> $past(en_q));  // R8
    AST_REJECT_HOLDS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $stable(base_q));  // R12

endmodule

// File: rtl/intc_acc_decode.sv
// Module: combinational translator from the access styles to the internal index.
// Legacy offsets drop their low nibble, and extended indices subtract EXT_BASE.
// Mode-dependent filtering is applied afterwards. Assumes ADDR_W > IDX_W + 4.
module intc_acc_decode
    import intc_xlate_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int IDX_W    = 6,
    parameter int EXT_BASE = 'h800,
    parameter int DFR_IDX  = 'h0E,
    parameter int CMD_IDX  = 'h30
) (
    input  intc_mode_e        mode_i,
    input  logic              wr_i,
    input  logic              ext_i,
    input  logic              wide_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              ok_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam int OFF_TOP = IDX_W + 4;
    localparam int NREG    = 1 << IDX_W;
    localparam logic [IDX_W-1:0] DFR_I  = IDX_W'(DFR_IDX);
    localparam logic [IDX_W-1:0] CMD_LO = IDX_W'(CMD_IDX);
    localparam logic [IDX_W-1:0] CMD_HI = IDX_W'(CMD_IDX + 1);

    logic [ADDR_W:0]  rel;
    logic             leg_ok, ext_ok;
    logic [IDX_W-1:0] leg_idx, ext_idx;

    // Legacy style: aligned offset inside the window, 32-bit only.
    always_comb begin
        leg_idx = addr_i[OFF_TOP-1:4];
        leg_ok  = !ext_i && !wide_i && (addr_i[3:0] == 4'h0)
                  && (addr_i[ADDR_W-1:OFF_TOP] == '0);
    end

    // Extended style: index in range, with the per-register restrictions.
    always_comb begin
        rel     = {1'b0, addr_i} - (ADDR_W+1)'(EXT_BASE);
        ext_idx = rel[IDX_W-1:0];
        ext_ok  = ext_i && (rel < (ADDR_W+1)'(NREG));
        if (ext_idx == DFR_I)                   ext_ok = 1'b0;
        if (ext_idx == CMD_HI)                  ext_ok = 1'b0;
        if (ext_idx == CMD_LO && wr_i && !wide_i) ext_ok = 1'b0;
        if (wide_i && ext_idx != CMD_LO)        ext_ok = 1'b0;
    end

    // Select by current mode.
    always_comb begin
        case (mode_i)
            MODE_LEGACY: begin ok_o = leg_ok; idx_o = leg_idx; end
            MODE_EXT:    begin ok_o = ext_ok; idx_o = ext_idx; end
            default:     begin ok_o = 1'b0;   idx_o = leg_idx; end
        endcase
    end

endmodule

// File: rtl/intc_rsp_stage.sv
// Module: one-cycle response register for accesses.
// Rejected accesses and writes return zero data. Assumes the register file read is combinational.
module intc_rsp_stage (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        ok_i,
    input  logic        wr_i,
    input  logic        wide_i,
    input  logic [63:0] rf_rdata_i,
    output logic        valid_o,
    output logic        err_o,
    output logic [63:0] rdata_o
);
    // Capture result of the access presented this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            rdata_o <= '0;
        end else begin
            valid_o <= req_i;
            err_o   <= req_i && !ok_i;
            if (req_i && ok_i && !wr_i)
                rdata_o <= wide_i ? rf_rdata_i : {32'h0, rf_rdata_i[31:0]};
            else
                rdata_o <= '0;
        end
    end

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (rdata_o == 64'h0));  // R11
    AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> valid_o);  // R11

endmodule

// File: rtl/intc_access_xlate.sv
// Module: top of the mode and access translator.
// It ties the control register, the style decoder and the response stage together,
// and drives the internal register file strobes. Assumes one access per cycle at most.
module intc_access_xlate
    import intc_xlate_pkg::*;
#(
    parameter int PHYS_W   = 40,
    parameter int ADDR_W   = 12,
    parameter int IDX_W    = 6,
    parameter int EXT_BASE = 'h800,
    parameter int DFR_IDX  = 'h0E,
    parameter int CMD_IDX  = 'h30,
    parameter logic [PHYS_W-13:0] BASE_RST = 'hFEE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [63:0]       ctl_wdata,
    output logic [63:0]       ctl_rdata,
    output logic              ctl_err,
    output logic [1:0]        mode,
    input  logic              acc_req,
    input  logic              acc_wr,
    input  logic              acc_ext,
    input  logic              acc_wide,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [63:0]       acc_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata,
    output logic              rf_rd,
    output logic              rf_wr,
    output logic              rf_wide,
    output logic [IDX_W-1:0]  rf_idx,
    output logic [63:0]       rf_wdata,
    input  logic [63:0]       rf_rdata
);
    intc_mode_e cur_mode;
    logic       acc_ok;

    intc_mode_ctrl #(.PHYS_W(PHYS_W), .BASE_RST(BASE_RST)) u_mode (
        .clk(clk), .rst_n(rst_n), .wr_i(ctl_wr), .wdata_i(ctl_wdata),
        .rdata_o(ctl_rdata), .err_o(ctl_err), .mode_o(cur_mode)
    );

    intc_acc_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .EXT_BASE(EXT_BASE),
                      .DFR_IDX(DFR_IDX), .CMD_IDX(CMD_IDX)) u_dec (
        .mode_i(cur_mode), .wr_i(acc_wr), .ext_i(acc_ext), .wide_i(acc_wide),
        .addr_i(acc_addr), .ok_o(acc_ok), .idx_o(rf_idx)
    );

    intc_rsp_stage u_rsp (
        .clk(clk), .rst_n(rst_n), .req_i(acc_req), .ok_i(acc_ok), .wr_i(acc_wr),
        .wide_i(acc_wide), .rf_rdata_i(rf_rdata),
        .valid_o(rsp_valid), .err_o(rsp_err), .rdata_o(rsp_rdata)
    );

    // Register file strobes fire only for accepted accesses.
    always_comb begin
        rf_rd    = acc_req && acc_ok && !acc_wr;
        rf_wr    = acc_req && acc_ok && acc_wr;
        rf_wide  = acc_wide;
        rf_wdata = acc_wdata;
        mode     = cur_mode;
    end

    AST_RF_ONLY_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_rd || rf_wr) |-> (cur_mode != MODE_OFF));  // R5
    AST_NO_DFR_IN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_mode == MODE_EXT) && (rf_rd || rf_wr)) |-> (rf_idx != IDX_W'(DFR_IDX)));  // R6
    AST_CMD_LO_WIDE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_mode == MODE_EXT) && rf_wr && (rf_idx == IDX_W'(CMD_IDX))) |-> rf_wide);  // R7
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |=> rsp_valid);  // R11

endmodule

// File: tb/test_intc_access_xlate.sv
// Bench: directed corners followed by seeded random control writes and accesses,
// checked against a mode model and a shadow of the stub register file.
module test_intc_access_xlate;
    localparam int PHYS_W   = 40;
    localparam int ADDR_W   = 12;
    localparam int IDX_W    = 6;
    localparam int EXT_BASE = 'h800;
    localparam int DFR_IDX  = 'h0E;
    localparam int CMD_IDX  = 'h30;
    localparam logic [27:0] BASE_RST = 28'hFEE00;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctl_wr = 1'b0;
    logic [63:0]       ctl_wdata = '0;
    logic [63:0]       ctl_rdata;
    logic              ctl_err;
    logic [1:0]        mode;
    logic              acc_req = 1'b0, acc_wr = 1'b0, acc_ext = 1'b0, acc_wide = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [63:0]       acc_wdata = '0;
    logic              rsp_valid, rsp_err;
    logic [63:0]       rsp_rdata;
    logic              rf_rd, rf_wr, rf_wide;
    logic [IDX_W-1:0]  rf_idx;
    logic [63:0]       rf_wdata, rf_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    intc_access_xlate #(.PHYS_W(PHYS_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
        .EXT_BASE(EXT_BASE), .DFR_IDX(DFR_IDX), .CMD_IDX(CMD_IDX),
        .BASE_RST(BASE_RST)) i_intc_access_xlate (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .ctl_err(ctl_err), .mode(mode),
        .acc_req(acc_req), .acc_wr(acc_wr), .acc_ext(acc_ext), .acc_wide(acc_wide),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_wide(rf_wide), .rf_idx(rf_idx),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    function automatic logic [31:0] stub_init(input int i);
        return 32'hC0DE_0000 | (i * 32'h111);
    endfunction

    // Stub register file: 64 words, combinational read, wide writes cover two words.
    logic [31:0] mem [64];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= stub_init(i);
        end else if (rf_wr) begin
            mem[rf_idx] <= rf_wdata[31:0];
            if (rf_wide) mem[rf_idx + 6'd1] <= rf_wdata[63:32];
        end
    end
    assign rf_rdata = {mem[rf_idx + 6'd1], mem[rf_idx]};

    // Bench model state.
    logic [31:0] shd [64];
    logic        b_en, b_ext;
    logic [27:0] b_base;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_mode();
        return b_ext ? 2'b10 : (b_en ? 2'b01 : 2'b00);
    endfunction

    function automatic logic [63:0] exp_ctl();
        return (64'(b_base) << 12) | (64'(b_en) << 11) | (64'(b_ext) << 10);
    endfunction

    function automatic logic ctl_legal(input logic ne, input logic nx);
        if (!b_en)  return !nx;
        if (!b_ext) return ne || !nx;
        return ne == nx;
    endfunction

    // Access model: returns accept flag and internal index from the requirements.
    function automatic logic acc_legal(input logic ext, input logic wide, input logic wr,
                                       input logic [11:0] addr, output logic [5:0] idx);
        int rel;
        idx = addr[9:4];
        if (!b_en) return 1'b0;
        if (!b_ext) return !ext && !wide && addr[3:0] == 0 && addr[11:10] == 0;
        if (!ext) return 1'b0;
        rel = int'(addr) - EXT_BASE;
        if (rel < 0 || rel >= 64) return 1'b0;
        idx = 6'(rel);
        if (idx == 6'(DFR_IDX) || idx == 6'(CMD_IDX + 1)) return 1'b0;
        if (idx == 6'(CMD_IDX)) return wide || !wr;
        return !wide;
    endfunction

    task automatic ctl_write(input logic ne, input logic nx, input logic [27:0] base,
                             input string req);
        logic ok;
        logic [63:0] wd;
        ok = ctl_legal(ne, nx);
        wd = (64'(base) << 12) | (64'(ne) << 11) | (64'(nx) << 10)
             | 64'($urandom & 32'h3FF) | (64'($urandom & 32'hFF_FFFF) << 40);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = wd;
        @(negedge clk);
        ctl_wr = 1'b0;
        if (ok) begin b_en = ne; b_ext = nx; b_base = base; end
        chk({req, " ctl_err"}, 64'(ctl_err), 64'(!ok));
        chk({req, " mode"}, 64'(mode), 64'(exp_mode()));
        chk({req, " ctl_rdata"}, ctl_rdata, exp_ctl());
    endtask

    task automatic access(input logic ext, input logic wide, input logic wr,
                          input logic [11:0] addr, input logic [63:0] wd, input string req);
        logic ok;
        logic [5:0] idx;
        logic [63:0] exp;
        ok = acc_legal(ext, wide, wr, addr, idx);
        exp = '0;
        if (ok && !wr) exp = wide ? {shd[idx + 6'd1], shd[idx]} : {32'h0, shd[idx]};
        @(negedge clk);
        acc_req = 1'b1; acc_ext = ext; acc_wide = wide; acc_wr = wr;
        acc_addr = addr; acc_wdata = wd;
        @(negedge clk);
        acc_req = 1'b0;
        if (ok && wr) begin
            shd[idx] = wd[31:0];
            if (wide) shd[idx + 6'd1] = wd[63:32];
        end
        chk({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk({req, " rsp_err"}, 64'(rsp_err), 64'(!ok));
        chk({req, " rsp_rdata"}, rsp_rdata, exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin : main
        int seed;
        seed = $urandom(32'h5EED_0423);
        for (int i = 0; i < 64; i++) shd[i] = stub_init(i);
        b_en = 1'b1; b_ext = 1'b0; b_base = BASE_RST;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R13: reset state
        chk("R1 mode", 64'(mode), 64'd1);
        chk("R1 ctl_rdata", ctl_rdata, {24'h0, BASE_RST, 12'h800});
        chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1 ctl_err", 64'(ctl_err), 64'd0);

        // R3: legacy translation and window edge
        access(1'b0, 1'b0, 1'b0, 12'h020, '0, "R3 read 0x020");
        access(1'b0, 1'b0, 1'b1, 12'h050, 64'h1234_5678, "R3 write 0x050");
        access(1'b0, 1'b0, 1'b0, 12'h050, '0, "R3 readback 0x050");
        access(1'b0, 1'b0, 1'b0, 12'h400, '0, "R3 beyond window");
        // R2: misaligned offsets, write must not land
        access(1'b0, 1'b0, 1'b0, 12'h024, '0, "R2 misaligned read");
        access(1'b0, 1'b0, 1'b1, 12'h028, 64'hDEAD, "R2 misaligned write");
        access(1'b0, 1'b0, 1'b0, 12'h020, '0, "R2 unchanged");
        // R5, R7: wrong style and wide in legacy
        access(1'b1, 1'b0, 1'b0, 12'h802, '0, "R5 ext style in legacy");
        access(1'b0, 1'b1, 1'b0, 12'h300, '0, "R7 wide in legacy");
        // R11: responses are single-cycle
        @(negedge clk);
        chk("R11 rsp_valid drops", 64'(rsp_valid), 64'd0);

        // R8, R12, R13: enter extended mode with new base
        ctl_write(1'b1, 1'b1, 28'h0ABCD, "R8 enter ext");
        // R4, R6, R7
        access(1'b1, 1'b0, 1'b0, 12'h802, '0, "R4 ext read");
        access(1'b1, 1'b0, 1'b0, 12'h7FF, '0, "R4 below window");
        access(1'b1, 1'b0, 1'b0, 12'h840, '0, "R4 above window");
        access(1'b1, 1'b0, 1'b0, 12'h80E, '0, "R6 dfr read");
        access(1'b1, 1'b0, 1'b1, 12'h80E, 64'h77, "R6 dfr write");
        access(1'b1, 1'b0, 1'b0, 12'h831, '0, "R7 cmd high read");
        access(1'b1, 1'b0, 1'b1, 12'h830, 64'h99, "R7 cmd low 32 write");
        access(1'b1, 1'b0, 1'b0, 12'h830, '0, "R7 cmd low 32 read");
        access(1'b1, 1'b1, 1'b1, 12'h830, 64'hAAAA_BBBB_CCCC_DDDD, "R7 wide write");
        access(1'b1, 1'b1, 1'b0, 12'h830, '0, "R7 wide read");
        access(1'b1, 1'b1, 1'b0, 12'h805, '0, "R7 wide elsewhere");
        access(1'b0, 1'b0, 1'b0, 12'h020, '0, "R5 legacy style in ext");

        // R9, R12: illegal exits keep everything
        ctl_write(1'b1, 1'b0, 28'h11111, "R9 direct exit");
        @(negedge clk);
        chk("R11 ctl_err single cycle", 64'(ctl_err), 64'd0);
        ctl_write(1'b0, 1'b1, 28'h22222, "R9 half exit");
        ctl_write(1'b0, 1'b0, 28'h33333, "R9 disable");
        access(1'b0, 1'b0, 1'b0, 12'h020, '0, "R5 disabled legacy");
        access(1'b1, 1'b0, 1'b0, 12'h802, '0, "R5 disabled ext");
        // R10
        ctl_write(1'b1, 1'b1, 28'h44444, "R10 ext from off");
        ctl_write(1'b0, 1'b1, 28'h55555, "R10 ext no enable");
        ctl_write(1'b1, 1'b0, BASE_RST, "R9 back to legacy");
        access(1'b0, 1'b0, 1'b0, 12'h300, '0, "R7 legacy sees wide-written word");

        // Random phase
        for (int n = 0; n < 700; n++) begin
            int r;
            logic ext, wide, wr;
            logic [11:0] addr;
            logic [5:0] ri;
            r = int'($urandom % 16);
            if (r == 0) begin
                ctl_write(1'($urandom), 1'($urandom), 28'($urandom), "R9 R10 R12 random ctl");
            end else begin
                ri   = 6'($urandom);
                ext  = b_ext;
                if ($urandom % 8 == 0) ext = !ext;
                wide = ($urandom % 8 == 0);
                wr   = 1'($urandom);
                addr = ext ? 12'(EXT_BASE + int'(ri)) : {2'b00, ri, 4'h0};
                if (wide && ($urandom % 2 == 0)) addr = 12'(EXT_BASE + CMD_IDX);
                if ($urandom % 16 == 0) addr = 12'($urandom);
                access(ext, wide, wr, addr, {$urandom, $urandom},
                       "R2 R3 R4 R5 R6 R7 R11 random access");
            end
        end

        summary();
        $finish;
    end

endmodule